// File: doc/BRIEF.md
# Two-Level Preemptive Transmit Merger

This block combines three byte-wide transmit queues into a single outgoing byte stream. The queues are the express queue, a high-priority preemptable queue and a low-priority preemptable queue. Each queue offers a frame as a valid/ready byte stream with a last flag. The output carries one byte per cycle, qualified by `tx_valid`. Every frame or fragment begins with a preamble and a delimiter byte. The delimiter tells the receiver whether the bytes that follow open a new frame or continue a preempted one. After every frame or fragment the line stays quiet for a fixed gap.

A preemptable frame in progress can be cut once enough of its current fragment has gone out. The cut fragment is closed with a fixed 4-byte check placeholder. The rest of the frame stays parked and is sent later behind a continuation delimiter and a fragment number byte. The express queue may cut either preemptable class. The high preemptable class may cut the low class only when the link partner reported two levels. The partner-level input selects among three modes. In level 0 every frame goes out express-style and uncut. In level 1 both preemptable classes act as one class. In level 2 the full two-level scheme applies.

The controller is one state machine with an active-class register. Its states are `ST_IDLE`, `ST_PRE`, `ST_DELIM`, `ST_FRAGNO`, `ST_DATA` and `ST_TRL`. Its transitions are:

- `ST_IDLE` to `ST_PRE` when the picker selects a queue.
- `ST_PRE` to `ST_DELIM` after 6 preamble bytes.
- `ST_DELIM` to `ST_FRAGNO` on a resume, or to `ST_DATA` on a new frame.
- `ST_FRAGNO` to `ST_DATA`.
- `ST_DATA` to `ST_TRL` on a cut, or to `ST_IDLE` on the last byte.
- `ST_TRL` to `ST_IDLE` after the 4th placeholder byte.

Top module: `pmerge_tx`

## Requirements
- R1: While reset is held, and afterwards with no queue offering data, `tx_valid` and all three ready outputs are low.
- R2: Every frame or fragment starts with 6 bytes of 0x55 followed by one delimiter byte. Express frames use the delimiter 0xD5 and are never cut.
- R3: From idle, an express frame may start as soon as the gap has expired. A preemptable frame additionally needs `tx_hold` low and no express frame pending. The order of service is express, then high preemptable, then low preemptable.
- R4: After the last byte of every frame or fragment, `tx_valid` stays low for exactly 12 cycles before the next preamble, provided a frame is waiting.
- R5: In levels 1 and 2, a new preemptable frame uses a start delimiter chosen by the 2-bit frame count: 0xE6, 0x4C, 0x7F and 0xB3 for counts 0 to 3.
- R6: The frame count is 0 after reset. It increases by one each time a preemptable frame sends its last byte in level 1 or 2. A parked frame keeps the count it started with.
- R7: A cut happens only when the current fragment has already carried at least 60 data bytes. The next data byte is replaced by the placeholder bytes 0xFF, 0xFF, 0x00, 0x00.
- R8: A high preemptable frame is cut only by an express frame, never by the low class. No class cuts a frame of its own class.
- R9: A resumed fragment sends the continuation delimiter for its stored frame count (0x61, 0x52, 0x2A, 0x9E for counts 0 to 3). It follows this with a fragment number byte coded like R5. The fragment number starts at 0 for each frame and increases by one with each resume.
- R10: In level 2, the high class may cut a low frame in progress. A parked low frame resumes only when no express or high frame is pending or parked.
- R11: In level 1, the high class never cuts a low frame. A parked frame resumes before any new high frame starts.
- R12: In level 0, every frame uses the express delimiter 0xD5 and runs uncut, whatever is pending.
- R13: At most one ready output is high in any cycle. The bytes of each queue appear on the output in order, one per accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| peer_levels | input | 2 | Preemption levels reported by the link partner (0, 1 or 2) |
| tx_hold | input | 1 | Blocks new preemptable starts and resumes |
| ex_valid | input | 1 | Express queue byte valid |
| ex_data | input | 8 | Express queue byte |
| ex_last | input | 1 | Last byte of the express frame |
| ex_ready | output | 1 | Express byte accepted |
| hi_valid | input | 1 | High preemptable queue byte valid |
| hi_data | input | 8 | High preemptable queue byte |
| hi_last | input | 1 | Last byte of the high preemptable frame |
| hi_ready | output | 1 | High preemptable byte accepted |
| lo_valid | input | 1 | Low preemptable queue byte valid |
| lo_data | input | 8 | Low preemptable queue byte |
| lo_last | input | 1 | Last byte of the low preemptable frame |
| lo_ready | output | 1 | Low preemptable byte accepted |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |

## Verification
The cut decision and the data path can fall in the same cycle. In the cycle where a fragment crosses its minimum length while a higher class is pending, the byte slot must carry the first placeholder byte and the source must not be acknowledged. The bench provokes this by raising the express or high queue partway through a long low frame. It then compares the whole captured stream against one built from the requirements. Any byte duplicated or lost at the cut shows up in the resumed fragment. A second collision is frame completion against parking: a completed high frame advances the count, and the resumed low fragment must still carry its older stored count.

// File: rtl/pmerge_pkg.sv
package pmerge_pkg;

    typedef enum logic [1:0] {
        CLS_EX = 2'd0,
        CLS_HI = 2'd1,
        CLS_LO = 2'd2,
        CLS_NO = 2'd3
    } cls_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRE    = 3'd1,
        ST_DELIM  = 3'd2,
        ST_FRAGNO = 3'd3,
        ST_DATA   = 3'd4,
        ST_TRL    = 3'd5
    } st_t;

    localparam logic [7:0] PRE_BYTE   = 8'h55;
    localparam logic [7:0] EXP_DELIM  = 8'hD5;

    // delimiter opening a new preemptable frame, also used for fragment numbers
    function automatic logic [7:0] start_code(input logic [1:0] n);
        logic [7:0] r;
        r = 8'hE6;
        case (n)
            2'd0: r = 8'hE6;
            2'd1: r = 8'h4C;
            2'd2: r = 8'h7F;
            2'd3: r = 8'hB3;
            default: r = 8'hE6;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] cont_code(input logic [1:0] n);
        logic [7:0] r;
        r = 8'h61;
        case (n)
            2'd0: r = 8'h61;
            2'd1: r = 8'h52;
            2'd2: r = 8'h2A;
            2'd3: r = 8'h9E;
            default: r = 8'h61;
        endcase
        return r;
    endfunction

    // fixed check placeholder closing a cut fragment
    function automatic logic [7:0] trl_byte(input logic [1:0] i);
        return i[1] ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/pmerge_gap.sv
module pmerge_gap #(
    parameter int IPG_BYTES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int GW = (IPG_BYTES > 2) ? $clog2(IPG_BYTES) : 1;

    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= GW'(IPG_BYTES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    // the counter never leaves its loaded range
    assert_gap_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == GW'(IPG_BYTES - 1)));

endmodule

// File: rtl/pmerge_ctx.sv
module pmerge_ctx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cut_i,
    input  logic       resume_i,
    input  logic [1:0] frm_i,
    output logic       parked_o,
    output logic [1:0] frm_o,
    output logic [1:0] frag_o
);
    logic       parked_q;
    logic [1:0] frm_q;
    logic [1:0] frag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parked_q <= 1'b0;
            frm_q    <= 2'd0;
            frag_q   <= 2'd0;
        end else begin
            if (start_i) begin
                parked_q <= 1'b0;
                frm_q    <= frm_i;
                frag_q   <= 2'd0;
            end
            if (cut_i) begin
                parked_q <= 1'b1;
            end
            if (resume_i) begin
                parked_q <= 1'b0;
                frag_q   <= frag_q + 2'd1;
            end
        end
    end

    assign parked_o = parked_q;
    assign frm_o    = frm_q;
    assign frag_o   = frag_q;

    // a continuation is only ever sent for a frame that was cut
    assert_resume_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_i |-> parked_q);

    // a parked frame keeps its frame count
    assert_park_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (parked_q && !start_i) |=> (frm_q == $past(frm_q)));

endmodule

// File: rtl/pmerge_pick.sv
module pmerge_pick
    import pmerge_pkg::*;
(
    input  logic       gap_done_i,
    input  logic       hold_i,
    input  logic [1:0] levels_i,
    input  logic       ex_v_i,
    input  logic       hi_v_i,
    input  logic       lo_v_i,
    input  logic       hi_park_i,
    input  logic       lo_park_i,
    output logic       go_o,
    output cls_t       cls_o,
    output logic       resume_o,
    output logic       frag_o
);
    always_comb begin
        go_o     = 1'b0;
        cls_o    = CLS_NO;
        resume_o = 1'b0;
        if (gap_done_i) begin
            if (ex_v_i) begin
                go_o  = 1'b1;
                cls_o = CLS_EX;
            end else if (!hold_i) begin
                unique case (levels_i)
                    2'd0: begin
                        if (hi_v_i) begin
                            go_o = 1'b1; cls_o = CLS_HI;
                        end else if (lo_v_i) begin
                            go_o = 1'b1; cls_o = CLS_LO;
                        end
                    end
                    2'd1: begin
                        if (hi_park_i) begin
                            go_o = 1'b1; cls_o = CLS_HI; resume_o = 1'b1;
                        end else if (lo_park_i) begin
                            go_o = 1'b1; cls_o = CLS_LO; resume_o = 1'b1;
                        end else if (hi_v_i) begin
                            go_o = 1'b1; cls_o = CLS_HI;
                        end else if (lo_v_i) begin
                            go_o = 1'b1; cls_o = CLS_LO;
                        end
                    end
                    default: begin
                        if (hi_park_i || hi_v_i) begin
                            go_o = 1'b1; cls_o = CLS_HI; resume_o = hi_park_i;
                        end else if (lo_park_i || lo_v_i) begin
                            go_o = 1'b1; cls_o = CLS_LO; resume_o = lo_park_i;
                        end
                    end
                endcase
            end
        end
        frag_o = go_o && (cls_o != CLS_EX) && (levels_i != 2'd0);
    end

endmodule

// File: rtl/pmerge_tx.sv
module pmerge_tx
    import pmerge_pkg::*;
#(
    parameter int MIN_FRAG  = 60,
    parameter int IPG_BYTES = 12,
    parameter int PRE_LEN   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] peer_levels,
    input  logic       tx_hold,
    input  logic       ex_valid,
    input  logic [7:0] ex_data,
    input  logic       ex_last,
    output logic       ex_ready,
    input  logic       hi_valid,
    input  logic [7:0] hi_data,
    input  logic       hi_last,
    output logic       hi_ready,
    input  logic       lo_valid,
    input  logic [7:0] lo_data,
    input  logic       lo_last,
    output logic       lo_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data
);
    localparam int FSW = $clog2(MIN_FRAG + 1);
    localparam int CW  = ($clog2(PRE_LEN) > 2) ? $clog2(PRE_LEN) : 2;

    st_t            state_q, state_n;
    cls_t           cls_q;
    logic           resume_q;
    logic           frag_q;
    logic [CW-1:0]  cnt_q;
    logic [FSW-1:0] fsize_q;
    logic [1:0]     frame_q;

    logic           gap_done, gap_load;
    logic           pick_go, pick_resume, pick_frag;
    cls_t           pick_cls;
    logic [1:0]     parked;
    logic [1:0]     frm_s   [2];
    logic [1:0]     fragn_s [2];
    logic [1:0]     act_frm, act_fragn;

    logic           sel_valid, sel_last;
    logic [7:0]     sel_data;
    logic           higher_pend, cut, send, two_level;

    assign two_level = (peer_levels >= 2'd2);

    // ---------------- submodules ----------------
    pmerge_gap #(.IPG_BYTES(IPG_BYTES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (gap_load),
        .done_o (gap_done)
    );

    pmerge_pick u_pick (
        .gap_done_i (gap_done && (state_q == ST_IDLE)),
        .hold_i     (tx_hold),
        .levels_i   (peer_levels),
        .ex_v_i     (ex_valid),
        .hi_v_i     (hi_valid),
        .lo_v_i     (lo_valid),
        .hi_park_i  (parked[0]),
        .lo_park_i  (parked[1]),
        .go_o       (pick_go),
        .cls_o      (pick_cls),
        .resume_o   (pick_resume),
        .frag_o     (pick_frag)
    );

    for (genvar k = 0; k < 2; k++) begin : g_ctx
        localparam cls_t KC = cls_t'(k + 1);
        pmerge_ctx u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  ((state_q == ST_IDLE) && pick_go && (pick_cls == KC) &&
                       !pick_resume && pick_frag),
            .cut_i    (cut && (cls_q == KC)),
            .resume_i ((state_q == ST_FRAGNO) && (cls_q == KC)),
            .frm_i    (frame_q),
            .parked_o (parked[k]),
            .frm_o    (frm_s[k]),
            .frag_o   (fragn_s[k])
        );
    end

    assign act_frm   = (cls_q == CLS_LO) ? frm_s[1]   : frm_s[0];
    assign act_fragn = (cls_q == CLS_LO) ? fragn_s[1] : fragn_s[0];

    // ---------------- source selection and cut decision ----------------
    always_comb begin
        sel_valid = 1'b0;
        sel_data  = 8'h00;
        sel_last  = 1'b0;
        unique case (cls_q)
            CLS_EX: begin sel_valid = ex_valid; sel_data = ex_data; sel_last = ex_last; end
            CLS_HI: begin sel_valid = hi_valid; sel_data = hi_data; sel_last = hi_last; end
            CLS_LO: begin sel_valid = lo_valid; sel_data = lo_data; sel_last = lo_last; end
            default: ;
        endcase
    end

    assign higher_pend = ex_valid || ((cls_q == CLS_LO) && two_level && hi_valid);
    assign cut  = (state_q == ST_DATA) && frag_q && (cls_q != CLS_EX) &&
                  (fsize_q >= FSW'(MIN_FRAG)) && higher_pend;
    assign send = (state_q == ST_DATA) && !cut && sel_valid;
    assign gap_load = (send && sel_last) || ((state_q == ST_TRL) && (cnt_q == CW'(3)));

    // ---------------- state register and counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cls_q    <= CLS_EX;
            resume_q <= 1'b0;
            frag_q   <= 1'b0;
            cnt_q    <= '0;
            fsize_q  <= '0;
            frame_q  <= 2'd0;
        end else begin
            state_q <= state_n;
            unique case (state_q)
                ST_IDLE: begin
                    if (pick_go) begin
                        cls_q    <= pick_cls;
                        resume_q <= pick_resume;
                        frag_q   <= pick_frag;
                        cnt_q    <= '0;
                        fsize_q  <= '0;
                    end
                end
                ST_PRE:  cnt_q <= cnt_q + 1'b1;
                ST_DATA: begin
                    if (cut) begin
                        cnt_q <= CW'(1);
                    end else if (send && (fsize_q < FSW'(MIN_FRAG))) begin
                        fsize_q <= fsize_q + 1'b1;
                    end
                end
                ST_TRL:  cnt_q <= cnt_q + 1'b1;
                default: ;
            endcase
            if (send && sel_last && frag_q) begin
                frame_q <= frame_q + 2'd1;
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (pick_go) state_n = ST_PRE;
            ST_PRE:    if (cnt_q == CW'(PRE_LEN - 1)) state_n = ST_DELIM;
            ST_DELIM:  state_n = resume_q ? ST_FRAGNO : ST_DATA;
            ST_FRAGNO: state_n = ST_DATA;
            ST_DATA: begin
                if (cut)                   state_n = ST_TRL;
                else if (send && sel_last) state_n = ST_IDLE;
            end
            ST_TRL:    if (cnt_q == CW'(3)) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        ex_ready = 1'b0;
        hi_ready = 1'b0;
        lo_ready = 1'b0;
        unique case (state_q)
            ST_PRE: begin
                tx_valid = 1'b1;
                tx_data  = PRE_BYTE;
            end
            ST_DELIM: begin
                tx_valid = 1'b1;
                if (!frag_q)       tx_data = EXP_DELIM;
                else if (resume_q) tx_data = cont_code(act_frm);
                else               tx_data = start_code(act_frm);
            end
            ST_FRAGNO: begin
                tx_valid = 1'b1;
                tx_data  = start_code(act_fragn);
            end
            ST_DATA: begin
                if (cut) begin
                    tx_valid = 1'b1;
                    tx_data  = trl_byte(2'd0);
                end else begin
                    tx_valid = sel_valid;
                    tx_data  = sel_data;
                end
                ex_ready = send && (cls_q == CLS_EX);
                hi_ready = send && (cls_q == CLS_HI);
                lo_ready = send && (cls_q == CLS_LO);
            end
            ST_TRL: begin
                tx_valid = 1'b1;
                tx_data  = trl_byte(cnt_q[1:0]);
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    assert_one_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ex_ready, hi_ready, lo_ready}));

    assert_start_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && (state_n == ST_PRE)) |-> gap_done);

    assert_cut_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && (state_n == ST_TRL)) |->
        ((cls_q != CLS_EX) && !((cls_q == CLS_HI) && !ex_valid)));

    assert_cut_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TRL) && ($past(state_q) == ST_DATA)) |->
        ($past(fsize_q) >= FSW'(MIN_FRAG)));

    assert_lo_resume_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FRAGNO) && (cls_q == CLS_LO) && two_level) |-> !parked[0]);

    assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && pick_go && (pick_cls != CLS_EX)) |-> (!tx_hold && !ex_valid));

    assert_level0_uncut_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DELIM) && (peer_levels == 2'd0) && $stable(peer_levels)) |-> !frag_q);

endmodule

// File: tb/pmerge_tx_bench.sv
module pmerge_tx_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] peer_levels = 2'd2;
    logic       tx_hold = 1'b0;
    logic       ex_valid, ex_last, ex_ready;
    logic       hi_valid, hi_last, hi_ready;
    logic       lo_valid, lo_last, lo_ready;
    logic [7:0] ex_data, hi_data, lo_data;
    logic       tx_valid;
    logic [7:0] tx_data;

    int len [3];
    int idx [3];
    int load_len [3];
    logic load [3];

    logic [7:0] cap [$];
    logic [7:0] exp_q [$];
    int gaps [$];
    int idle_run;
    logic seen;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmerge_tx u_pmerge_tx (
        .clk(clk), .rst_n(rst_n), .peer_levels(peer_levels), .tx_hold(tx_hold),
        .ex_valid(ex_valid), .ex_data(ex_data), .ex_last(ex_last), .ex_ready(ex_ready),
        .hi_valid(hi_valid), .hi_data(hi_data), .hi_last(hi_last), .hi_ready(hi_ready),
        .lo_valid(lo_valid), .lo_data(lo_data), .lo_last(lo_last), .lo_ready(lo_ready),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    function automatic logic [7:0] dbyte(input int c, input int i);
        return 8'(i + c * 80);
    endfunction

    assign ex_valid = idx[0] < len[0];
    assign hi_valid = idx[1] < len[1];
    assign lo_valid = idx[2] < len[2];
    assign ex_data  = dbyte(0, idx[0]);
    assign hi_data  = dbyte(1, idx[1]);
    assign lo_data  = dbyte(2, idx[2]);
    assign ex_last  = idx[0] == len[0] - 1;
    assign hi_last  = idx[1] == len[1] - 1;
    assign lo_last  = idx[2] == len[2] - 1;

    // queue models: one frame per load
    always @(posedge clk) begin
        for (int c = 0; c < 3; c++) begin
            if (!rst_n) begin
                idx[c] <= 0;
                len[c] <= 0;
            end else if (load[c]) begin
                idx[c] <= 0;
                len[c] <= load_len[c];
            end else if ((c == 0 && ex_ready) || (c == 1 && hi_ready) || (c == 2 && lo_ready)) begin
                idx[c] <= idx[c] + 1;
            end
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            idle_run = 0;
            seen = 1'b0;
        end else if (tx_valid) begin
            cap.push_back(tx_data);
            if (seen && idle_run > 0) gaps.push_back(idle_run);
            idle_run = 0;
            seen = 1'b1;
        end else begin
            idle_run++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic do_reset(input logic [1:0] lvl);
        rst_n = 1'b0;
        peer_levels = lvl;
        tx_hold = 1'b0;
        for (int c = 0; c < 3; c++) load[c] = 1'b0;
        repeat (3) @(negedge clk);
        cap.delete();
        gaps.delete();
        exp_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_srcs(input int n0, input int n1, input int n2);
        load_len[0] = n0; load_len[1] = n1; load_len[2] = n2;
        load[0] = (n0 > 0); load[1] = (n1 > 0); load[2] = (n2 > 0);
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 3; c++) load[c] = 1'b0;
    endtask

    task automatic wait_cap(input int n);
        while (cap.size() < n) @(negedge clk);
    endtask

    task automatic wait_quiet();
        int q;
        q = 0;
        while (q < 30) begin
            @(negedge clk);
            if (tx_valid || ex_valid || hi_valid || lo_valid) q = 0;
            else q++;
        end
    endtask

    task automatic push_pre(input logic [7:0] delim);
        for (int i = 0; i < 6; i++) exp_q.push_back(8'h55);
        exp_q.push_back(delim);
    endtask

    task automatic push_data(input int c, input int a, input int b);
        for (int i = a; i <= b; i++) exp_q.push_back(dbyte(c, i));
    endtask

    task automatic push_trl();
        exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
        exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    endtask

    task automatic check_stream(input string tag);
        checks++;
        if (cap.size() != exp_q.size()) begin
            errors++;
            $display("FAIL %s: stream length actual=%0d expected=%0d", tag, cap.size(), exp_q.size());
            return;
        end
        for (int i = 0; i < cap.size(); i++) begin
            if (cap[i] !== exp_q[i]) begin
                errors++;
                $display("FAIL %s: byte %0d actual=%02h expected=%02h", tag, i, cap[i], exp_q[i]);
                return;
            end
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_int("R1 in reset tx_valid", int'(tx_valid), 0);
        do_reset(2'd2);
        repeat (5) @(negedge clk);
        check_int("R1 idle outputs", int'({tx_valid, ex_ready, hi_ready, lo_ready}), 0);
    endtask

    task automatic t_express();
        do_reset(2'd2);
        start_srcs(20, 0, 0);
        wait_quiet();
        push_pre(8'hD5); push_data(0, 0, 19);
        check_stream("R2 R13 express frame");
    endtask

    task automatic t_cut_by_express();
        do_reset(2'd2);
        start_srcs(0, 0, 160);
        wait_cap(37);
        start_srcs(20, 0, 0);
        wait_cap(126);
        start_srcs(20, 0, 0);
        wait_quiet();
        start_srcs(0, 5, 0);
        wait_quiet();
        push_pre(8'hE6); push_data(2, 0, 59); push_trl();
        push_pre(8'hD5); push_data(0, 0, 19);
        push_pre(8'h61); exp_q.push_back(8'hE6); push_data(2, 60, 119); push_trl();
        push_pre(8'hD5); push_data(0, 0, 19);
        push_pre(8'h61); exp_q.push_back(8'h4C); push_data(2, 120, 159);
        push_pre(8'h4C); push_data(1, 0, 4);
        check_stream("R7 R9 R5 R6 double cut of low frame by express");
        check_int("R4 gap after cut fragment", (gaps.size() > 0) ? gaps[0] : -1, 12);
    endtask

    task automatic t_cut_by_high();
        do_reset(2'd2);
        start_srcs(0, 0, 100);
        wait_cap(37);
        start_srcs(0, 70, 0);
        wait_quiet();
        start_srcs(0, 3, 0);
        wait_quiet();
        push_pre(8'hE6); push_data(2, 0, 59); push_trl();
        push_pre(8'hE6); push_data(1, 0, 69);
        push_pre(8'h61); exp_q.push_back(8'hE6); push_data(2, 60, 99);
        push_pre(8'h7F); push_data(1, 0, 2);
        check_stream("R10 R6 low frame cut by high class");
    endtask

    task automatic t_high_not_cut();
        do_reset(2'd2);
        start_srcs(0, 100, 0);
        wait_cap(37);
        start_srcs(0, 0, 10);
        wait_quiet();
        push_pre(8'hE6); push_data(1, 0, 99);
        push_pre(8'h4C); push_data(2, 0, 9);
        check_stream("R8 high frame not cut by low");
    endtask

    task automatic t_level1();
        do_reset(2'd1);
        start_srcs(0, 0, 100);
        wait_cap(37);
        start_srcs(0, 10, 0);
        wait_quiet();
        push_pre(8'hE6); push_data(2, 0, 99);
        push_pre(8'h4C); push_data(1, 0, 9);
        check_stream("R11 level 1 single preemptable level");
    endtask

    task automatic t_level0();
        do_reset(2'd0);
        start_srcs(0, 0, 100);
        wait_cap(37);
        start_srcs(10, 0, 0);
        wait_quiet();
        start_srcs(0, 5, 0);
        wait_quiet();
        push_pre(8'hD5); push_data(2, 0, 99);
        push_pre(8'hD5); push_data(0, 0, 9);
        push_pre(8'hD5); push_data(1, 0, 4);
        check_stream("R12 level 0 express-style uncut");
    endtask

    task automatic t_hold();
        do_reset(2'd2);
        tx_hold = 1'b1;
        start_srcs(0, 10, 0);
        repeat (40) @(negedge clk);
        check_int("R3 hold blocks preemptable start", cap.size(), 0);
        start_srcs(10, 0, 0);
        repeat (60) @(negedge clk);
        push_pre(8'hD5); push_data(0, 0, 9);
        check_stream("R3 express passes hold");
        tx_hold = 1'b0;
        wait_quiet();
        push_pre(8'hE6); push_data(1, 0, 9);
        check_stream("R3 preemptable after hold release");
    endtask

    task automatic t_priority();
        do_reset(2'd2);
        start_srcs(10, 10, 10);
        wait_quiet();
        push_pre(8'hD5); push_data(0, 0, 9);
        push_pre(8'hE6); push_data(1, 0, 9);
        push_pre(8'h4C); push_data(2, 0, 9);
        check_stream("R3 service order express high low");
        check_int("R4 gap count", gaps.size(), 2);
        check_int("R4 first gap", (gaps.size() > 0) ? gaps[0] : -1, 12);
        check_int("R4 second gap", (gaps.size() > 1) ? gaps[1] : -1, 12);
    endtask

    initial begin
        for (int c = 0; c < 3; c++) begin
            load[c] = 1'b0;
            load_len[c] = 0;
        end
        t_reset();
        t_express();
        t_cut_by_express();
        t_cut_by_high();
        t_high_not_cut();
        t_level1();
        t_level0();
        t_hold();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule